// File: doc/BRIEF.md
# Stack Bytecode Instruction Length Decoder

This block takes a stream of stack-machine bytecode, one byte per accepted input beat, and cuts it into whole instructions. For each instruction it reports the opcode byte, whether a widening prefix came before it, the operand assembled from the bytes that follow it, the total instruction length in bytes, and a flag for opcodes it does not recognise. A front end that fetches bytecode sits on the input side. A dispatch or execute stage takes one decoded instruction per output handshake.

The length depends on the opcode class: zero, one or two operand bytes. The prefix byte 0xC4 changes the class of the opcode that follows it, so the length is not a fixed property of each opcode. Operands of two bytes arrive most-significant byte first. Depending on the opcode, the operand is either sign-extended or zero-extended to the output width.

Control is a four-state machine:
- ST_OPCODE waits for an opcode.
- ST_WIDE_OPC waits for the opcode after a prefix.
- ST_OPERAND collects the remaining operand bytes.
- ST_EMIT holds a finished instruction at the output.

The transitions are:
- opcode-to-emit for single-byte or unknown opcodes.
- opcode-to-wide on the prefix.
- opcode-to-operand for opcodes that carry operands.
- wide-to-operand when the prefix is followed by 0x15.
- wide-to-emit when the prefix is followed by any other byte.
- operand-to-emit on the last operand byte.
- emit-to-opcode when the output is accepted with no new byte.
- emit-to-next-instruction when the output is accepted and a new byte is taken in the same cycle.

Top module: `bcd_len_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: These opcodes produce an instruction of length 1 with operand 0 and the illegal flag clear: 0x00–0x0F, 0x1A–0x2D, 0x57–0x83 and 0xAC–0xB1. This set includes add 0x60, pop 0x57, 0x1B and 0x03.
- R3: Opcodes 0x15 and 0x12 take one operand byte, have length 2, and zero-extend that byte.
- R4: Opcode 0x10 takes one operand byte, has length 2, and sign-extends that byte.
- R5: Opcodes 0x11 and 0x13 take two operand bytes, have length 3, and take the first operand byte as the high byte. The operand of 0x11 is sign-extended and the operand of 0x13 is zero-extended, so 0x13 0x01 0x01 gives 257.
- R6: Opcodes 0x99–0xA7 and 0xC6–0xC7 carry a 16-bit big-endian offset, have length 3, and output that offset sign-extended.
- R7: The prefix 0xC4 followed by 0x15 yields one instruction with opcode 0x15, out_wide set to 1, length 4, and the following two bytes as a big-endian, zero-extended index.
- R8: The prefix 0xC4 followed by any byte other than 0x15 yields one instruction with that byte as opcode, out_wide 1, out_illegal 1, length 2 and operand 0.
- R9: Any opcode outside the sets above, other than 0xC4, yields a length-1 instruction with out_illegal 1 and operand 0.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0, no input byte is consumed, and all output fields hold their values.
- R11: When the output is accepted in the same cycle that a byte is offered, that byte is consumed. With out_ready held at 1, a run of single-byte instructions emits one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_byte | input | 8 | Bytecode byte |
| in_ready | output | 1 | Decoder accepts the offered byte |
| out_valid | output | 1 | A decoded instruction is presented |
| out_ready | input | 1 | Consumer takes the instruction |
| out_opcode | output | 8 | Opcode byte (the byte after the prefix when widened) |
| out_wide | output | 1 | A 0xC4 prefix preceded the opcode |
| out_illegal | output | 1 | Opcode not in the supported set |
| out_operand | output | OPND_W | Assembled and extended operand |
| out_len | output | LEN_W | Instruction length in bytes, prefix included |

## Verification
A table walks each opcode class with operand values on both sides of the sign boundary, such as 0xFE against 0x05 and 0x8000 against 0x0102. This separates sign extension from zero extension, and it separates big-endian assembly from a swapped byte order. Each side of the range is probed with a byte just past it, for example 0x98, 0xA8 and 0xC8. This exposes an off-by-one in the branch and one-byte classification. The prefix is tried both with 0x15 and with an ordinary opcode after it, which checks that widening happens only in the one legal case. Directed sequences hold the output with a byte waiting, then release it. They also stream single-byte opcodes with the output always ready. Together these show that no byte is lost or duplicated across the output handshake.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [2:0] {
        OC_NONE,   // no operand byte
        OC_U8,     // one byte, zero-extended
        OC_S8,     // one byte, sign-extended
        OC_U16,    // two bytes, zero-extended
        OC_S16,    // two bytes, sign-extended
        OC_WIDE,   // widening prefix
        OC_BAD     // not supported
    } opnd_cls_e;

    typedef enum logic [1:0] {
        ST_OPCODE,
        ST_WIDE_OPC,
        ST_OPERAND,
        ST_EMIT
    } dec_state_e;

    localparam logic [7:0] OPC_PREFIX = 8'hC4;
    localparam logic [7:0] OPC_ILOAD  = 8'h15;

    function automatic logic [1:0] cls_bytes(input opnd_cls_e c);
        unique case (c)
            OC_U8, OC_S8:   return 2'd1;
            OC_U16, OC_S16: return 2'd2;
            default:        return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bcd_classify.sv
module bcd_classify
    import bcd_pkg::*;
(
    input  logic [7:0] opc,
    output opnd_cls_e  cls
);

    always_comb begin
        if (opc == OPC_PREFIX)
            cls = OC_WIDE;
        else if (opc == 8'h15 || opc == 8'h12)
            cls = OC_U8;
        else if (opc == 8'h10)
            cls = OC_S8;
        else if (opc == 8'h13)
            cls = OC_U16;
        else if (opc == 8'h11)
            cls = OC_S16;
        else if ((opc >= 8'h99 && opc <= 8'hA7) || opc == 8'hC6 || opc == 8'hC7)
            cls = OC_S16;
        else if (opc <= 8'h0F
                 || (opc >= 8'h1A && opc <= 8'h2D)
                 || (opc >= 8'h57 && opc <= 8'h83)
                 || (opc >= 8'hAC && opc <= 8'hB1))
            cls = OC_NONE;
        else
            cls = OC_BAD;
    end

endmodule

// File: rtl/bcd_operand.sv
module bcd_operand
    import bcd_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic [7:0]        byte_in,
    input  opnd_cls_e         cls,
    output logic [OPND_W-1:0] value
);

    localparam int RAW_W = 16;

    logic [RAW_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else if (shift)
            acc_q <= {acc_q[RAW_W-9:0], byte_in};
    end

    always_comb begin
        unique case (cls)
            OC_U8:   value = {{(OPND_W-8){1'b0}}, acc_q[7:0]};
            OC_S8:   value = {{(OPND_W-8){acc_q[7]}}, acc_q[7:0]};
            OC_U16:  value = {{(OPND_W-RAW_W){1'b0}}, acc_q};
            OC_S16:  value = {{(OPND_W-RAW_W){acc_q[RAW_W-1]}}, acc_q};
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/bcd_len_decoder.sv
module bcd_len_decoder
    import bcd_pkg::*;
#(
    parameter int OPND_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_opcode,
    output logic              out_wide,
    output logic              out_illegal,
    output logic [OPND_W-1:0] out_operand,
    output logic [LEN_W-1:0]  out_len
);

    dec_state_e       state_q, state_d;
    logic [7:0]       opc_q, opc_d;
    logic             wide_q, wide_d;
    logic             ill_q, ill_d;
    opnd_cls_e        cls_q, cls_d;
    logic [1:0]       left_q, left_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             acc_clr, acc_shift, take;
    opnd_cls_e        cls_in;

    bcd_classify u_cls (
        .opc (in_byte),
        .cls (cls_in)
    );

    bcd_operand #(.OPND_W(OPND_W)) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .shift   (acc_shift),
        .byte_in (in_byte),
        .cls     (cls_q),
        .value   (out_operand)
    );

    assign out_valid = (state_q == ST_EMIT);
    assign in_ready  = !out_valid || out_ready;
    assign take      = in_valid && in_ready;

    always_comb begin
        state_d   = state_q;
        opc_d     = opc_q;
        wide_d    = wide_q;
        ill_d     = ill_q;
        cls_d     = cls_q;
        left_d    = left_q;
        len_d     = len_q;
        acc_clr   = 1'b0;
        acc_shift = 1'b0;
        unique case (state_q)
            ST_OPCODE, ST_EMIT: begin
                if (state_q == ST_EMIT && out_ready)
                    state_d = ST_OPCODE;
                if (take) begin
                    acc_clr = 1'b1;
                    opc_d   = in_byte;
                    wide_d  = 1'b0;
                    ill_d   = 1'b0;
                    cls_d   = OC_NONE;
                    left_d  = 2'd0;
                    len_d   = LEN_W'(1);
                    unique case (cls_in)
                        OC_WIDE: begin
                            wide_d  = 1'b1;
                            state_d = ST_WIDE_OPC;
                        end
                        OC_NONE: state_d = ST_EMIT;
                        OC_BAD: begin
                            ill_d   = 1'b1;
                            state_d = ST_EMIT;
                        end
                        default: begin
                            cls_d   = cls_in;
                            left_d  = cls_bytes(cls_in);
                            state_d = ST_OPERAND;
                        end
                    endcase
                end
            end
            ST_WIDE_OPC: begin
                if (take) begin
                    opc_d = in_byte;
                    len_d = len_q + LEN_W'(1);
                    if (in_byte == OPC_ILOAD) begin
                        cls_d   = OC_U16;
                        left_d  = 2'd2;
                        state_d = ST_OPERAND;
                    end else begin
                        ill_d   = 1'b1;
                        state_d = ST_EMIT;
                    end
                end
            end
            ST_OPERAND: begin
                if (take) begin
                    acc_shift = 1'b1;
                    len_d     = len_q + LEN_W'(1);
                    left_d    = left_q - 2'd1;
                    if (left_q == 2'd1)
                        state_d = ST_EMIT;
                end
            end
            default: state_d = ST_OPCODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            opc_q   <= '0;
            wide_q  <= 1'b0;
            ill_q   <= 1'b0;
            cls_q   <= OC_NONE;
            left_q  <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            opc_q   <= opc_d;
            wide_q  <= wide_d;
            ill_q   <= ill_d;
            cls_q   <= cls_d;
            left_q  <= left_d;
            len_q   <= len_d;
        end
    end

    assign out_opcode  = opc_q;
    assign out_wide    = wide_q;
    assign out_illegal = ill_q;
    assign out_len     = len_q;

endmodule

// File: rtl/bcd_len_decoder_chk.sv
module bcd_len_decoder_chk #(
    parameter int OPND_W = 32,
    parameter int LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        in_byte,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_opcode,
    input logic              out_wide,
    input logic              out_illegal,
    input logic [OPND_W-1:0] out_operand,
    input logic [LEN_W-1:0]  out_len
);

    a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_opcode)
            && $stable(out_operand) && $stable(out_len) && $stable(out_wide)
            && $stable(out_illegal));

    a_r11_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |-> in_ready);

    a_r9_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_illegal && !out_wide |-> out_len == LEN_W'(1) && out_operand == '0);

    a_r7_wide_len: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_wide && !out_illegal |-> out_len == LEN_W'(4) && out_opcode == 8'h15);

    a_r8_wide_bad: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_wide && out_illegal |-> out_len == LEN_W'(2));

    a_r6_branch_len: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_wide
            && ((out_opcode >= 8'h99 && out_opcode <= 8'hA7) || out_opcode == 8'hC6 || out_opcode == 8'hC7)
            |-> out_len == LEN_W'(3));

endmodule

bind bcd_len_decoder bcd_len_decoder_chk #(.OPND_W(OPND_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/bcd_len_decoder_tb.sv
`timescale 1ns/1ps
module bcd_len_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic        out_wide;
    logic        out_illegal;
    logic [31:0] out_operand;
    logic [2:0]  out_len;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bcd_len_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_wide(out_wide), .out_illegal(out_illegal),
        .out_operand(out_operand), .out_len(out_len)
    );

    // {bytes[31:0] first byte high, len[2:0], opcode[7:0], wide, operand[31:0], illegal}
    localparam int NV = 20;
    localparam logic [76:0] VEC [NV] = '{
        {32'h6000_0000, 3'd1, 8'h60, 1'b0, 32'h0000_0000, 1'b0},  // R2 add
        {32'h5700_0000, 3'd1, 8'h57, 1'b0, 32'h0000_0000, 1'b0},  // R2 pop
        {32'h1B00_0000, 3'd1, 8'h1B, 1'b0, 32'h0000_0000, 1'b0},  // R2
        {32'h0300_0000, 3'd1, 8'h03, 1'b0, 32'h0000_0000, 1'b0},  // R2
        {32'h1507_0000, 3'd2, 8'h15, 1'b0, 32'h0000_0007, 1'b0},  // R3
        {32'h1280_0000, 3'd2, 8'h12, 1'b0, 32'h0000_0080, 1'b0},  // R3 zero-ext
        {32'h10FE_0000, 3'd2, 8'h10, 1'b0, 32'hFFFF_FFFE, 1'b0},  // R4 negative
        {32'h1005_0000, 3'd2, 8'h10, 1'b0, 32'h0000_0005, 1'b0},  // R4
        {32'h1180_0000, 3'd3, 8'h11, 1'b0, 32'hFFFF_8000, 1'b0},  // R5 signed
        {32'h1101_0200, 3'd3, 8'h11, 1'b0, 32'h0000_0102, 1'b0},  // R5 order
        {32'h1301_0100, 3'd3, 8'h13, 1'b0, 32'h0000_0101, 1'b0},  // R5 257
        {32'hA7FF_FD00, 3'd3, 8'hA7, 1'b0, 32'hFFFF_FFFD, 1'b0},  // R6
        {32'h9900_1000, 3'd3, 8'h99, 1'b0, 32'h0000_0010, 1'b0},  // R6
        {32'hC780_0000, 3'd3, 8'hC7, 1'b0, 32'hFFFF_8000, 1'b0},  // R6
        {32'hC415_0100, 3'd4, 8'h15, 1'b1, 32'h0000_0100, 1'b0},  // R7
        {32'hC415_FFFF, 3'd4, 8'h15, 1'b1, 32'h0000_FFFF, 1'b0},  // R7 zero-ext
        {32'hC460_0000, 3'd2, 8'h60, 1'b1, 32'h0000_0000, 1'b1},  // R8
        {32'hC800_0000, 3'd1, 8'hC8, 1'b0, 32'h0000_0000, 1'b1},  // R9
        {32'hA800_0000, 3'd1, 8'hA8, 1'b0, 32'h0000_0000, 1'b1},  // R9
        {32'h9800_0000, 3'd1, 8'h98, 1'b0, 32'h0000_0000, 1'b1}   // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic accept();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd1);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] bs;
            int          n;
            bs = VEC[v][76:45];
            n  = int'(VEC[v][44:42]);
            for (int b = 0; b < n; b++) send(bs[31-8*b -: 8]);
            check($sformatf("vec%0d valid", v), 32'(out_valid), 32'd1);
            check($sformatf("vec%0d opcode", v), 32'(out_opcode), 32'(VEC[v][41:34]));
            check($sformatf("vec%0d wide", v), 32'(out_wide), 32'(VEC[v][33]));
            check($sformatf("vec%0d operand", v), out_operand, VEC[v][32:1]);
            check($sformatf("vec%0d len", v), 32'(out_len), 32'(VEC[v][44:42]));
            check($sformatf("vec%0d illegal", v), 32'(out_illegal), 32'(VEC[v][0]));
            accept();
            check($sformatf("vec%0d drained", v), 32'(out_valid), 32'd0);
        end

        // R10: hold output with a byte waiting
        send(8'h11); send(8'h12); send(8'h34);
        in_valid = 1'b1;
        in_byte  = 8'h57;
        repeat (3) @(negedge clk);
        check("R10 in_ready low", 32'(in_ready), 32'd0);
        check("R10 still valid", 32'(out_valid), 32'd1);
        check("R10 operand held", out_operand, 32'h0000_1234);
        check("R10 opcode held", 32'(out_opcode), 32'h11);
        // R11: release; waiting byte taken in same cycle
        out_ready = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check("R11 next opcode", 32'(out_opcode), 32'h57);
        check("R11 next len", 32'(out_len), 32'd1);
        check("R11 next valid", 32'(out_valid), 32'd1);
        accept();

        // R11: back-to-back single-byte stream
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_byte   = 8'h60;
        @(negedge clk);
        check("R11 stream0", 32'(out_opcode), 32'h60);
        check("R11 stream0 ready", 32'(in_ready), 32'd1);
        in_byte = 8'h03;
        @(negedge clk);
        check("R11 stream1", 32'(out_opcode), 32'h03);
        in_byte = 8'h1B;
        @(negedge clk);
        check("R11 stream2", 32'(out_opcode), 32'h1B);
        check("R11 stream2 valid", 32'(out_valid), 32'd1);
        in_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        check("R11 stream end", 32'(out_valid), 32'd0);

        // R1: reset in the middle of an instruction
        send(8'hC4);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid reset valid", 32'(out_valid), 32'd0);
        send(8'h15); send(8'h09);
        check("R1 after reset wide", 32'(out_wide), 32'd0);
        check("R3 after reset operand", out_operand, 32'd9);
        accept();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule